// File: doc/BRIEF.md
# Delayed Read Completion Tracker

This block handles delayed reads on one side of a bus bridge. The first time an initiator presents a read, the block stores the request in a small queue and answers with Retry. It then issues a fetch toward the target side, with a byte count chosen from the command, the address space, the cache-line size, the direction and a per-direction promotion bit. The target side writes the fetched words into a per-entry buffer and reports how its transfer ended.

When the initiator presents the same read again, the block looks for a queued entry whose captured fields are all equal to those of the repeat. If that entry's fetch is still running, the initiator gets Retry again. If the fetch has finished, the block answers with a termination that reflects the target-side outcome and streams the stored words back. It then frees the entry. A master abort on the target side is returned as one beat of all-ones data. That beat is 32 or 64 bits wide.

Top module: `drc_tracker`

## Requirements
- R1: A request whose fields match no queued entry, arriving while a slot is free and no data is being returned, is stored in the lowest free slot. One cycle later `rsp_valid` is high with `rsp_code` 0 (Retry), and `iss_valid` is high with that slot's tag, the request address and command, and the fetch size in `iss_bytes`. Command codes are: 0 memory read, 1 memory read line, 2 memory read multiple, 3 I/O read, 4 configuration read.
- R2: I/O reads, configuration reads, and every read with `req_pref` low fetch 4 bytes, whatever the cache-line size and promotion bits.
- R3: A prefetchable memory read (code 0) fetches 32 bytes when `cls` is 8 and 64 bytes when `cls` is 16, in either direction.
- R4: Any `cls` value other than 8 or 16 gives the same fetch size as `cls` = 8.
- R5: A prefetchable memory read line (code 1) follows R3 when the promotion bit for its direction (`prom_up` when `req_up` is 1, otherwise `prom_dn`) is clear. With that bit set it fetches 64 bytes downstream, 64 bytes upstream with `cls` 8, and 128 bytes upstream with `cls` 16. The other direction's bit has no effect.
- R6: A prefetchable memory read multiple (code 2) fetches 64 bytes downstream and 256 bytes upstream, for any `cls`.
- R7: A repeat matches an entry only when address, command, `req_64` and byte enables are all equal. A request that differs in any of these is handled as a new request.
- R8: A repeat that matches an entry whose target side has not yet reported (`td_valid`) is answered with Retry. Nothing is issued, and the entry stays queued.
- R9: A repeat that matches an entry the target side reported as normal (`td_term` 0) is answered with code 1 (Completion). The stored words 0 to `td_words`-1 then follow, one per cycle starting the cycle after the response, in the low 32 bits of `dat` with the upper 32 bits zero. `dat_last` is high on the final word. The entry is then freed, so the same request afterwards is captured again.
- R10: Target-side disconnect (`td_term` 1) is answered with code 2 (Disconnect) and the stored words as in R9. Target abort (`td_term` 2) is answered with code 3 (Target-Abort), and no data beat follows.
- R11: Target-side master abort (`td_term` 3) is answered with code 4 (Master-Abort) and one data beat with `dat_last` high. The low 32 bits of that beat are all ones. The upper 32 bits are all ones only when the request had `req_64` set and the target reported `td_ack64`, and zero otherwise.
- R12: For a 4-byte fetch that ended normally, a repeat with `req_multi` high (the initiator asks for more than one DWORD) is answered with code 2 (Disconnect) instead of Completion.
- R13: A new request that matches no entry while all slots are occupied is answered with Retry, is not captured, and issues nothing.
- R14: A request that arrives while stored data is being returned is answered with Retry. It issues nothing and frees nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cls | input | 8 | Cache-line size in DWORDs |
| prom_dn | input | 1 | Read-line promotion, downstream |
| prom_up | input | 1 | Read-line promotion, upstream |
| req_valid | input | 1 | Initiator read request present |
| req_addr | input | ADDR_W | Request address |
| req_cmd | input | 3 | Read command code |
| req_be | input | BE_W | Byte enables |
| req_64 | input | 1 | Initiator asks for a 64-bit transfer |
| req_pref | input | 1 | Address lies in prefetchable space |
| req_up | input | 1 | Request travels upstream |
| req_multi | input | 1 | Initiator wants more than one DWORD |
| rsp_valid | output | 1 | Termination code valid |
| rsp_code | output | 3 | Termination returned to the initiator |
| iss_valid | output | 1 | Fetch issued to target side |
| iss_tag | output | TAG_W | Slot of the issued fetch |
| iss_addr | output | ADDR_W | Fetch address |
| iss_cmd | output | 3 | Fetch command |
| iss_bytes | output | 9 | Fetch size in bytes |
| tw_valid | input | 1 | Target data word write |
| tw_tag | input | TAG_W | Slot of the written word |
| tw_idx | input | IDX_W | Word index within the slot |
| tw_data | input | 32 | Fetched word |
| td_valid | input | 1 | Target side finished a fetch |
| td_tag | input | TAG_W | Slot that finished |
| td_term | input | 2 | Target-side ending |
| td_words | input | IDX_W+1 | Number of words stored |
| td_ack64 | input | 1 | Target accepted a 64-bit transfer |
| dat_valid | output | 1 | Returned data beat |
| dat_last | output | 1 | Final beat |
| dat | output | 64 | Returned data |

## Verification
The sharpest corners are in the fetch-size choice. A cache-line size that is neither 8 nor 16 must fall back to 32 bytes, not to 64 or to 4. The promotion bit of the opposite direction must be ignored, and non-prefetchable memory commands must drop to 4 bytes. A table covers each of these cases. The directed tests then go after matching and termination. A repeat differing only in byte enables must not pick up another entry's data. A pending match must not stream stale buffer contents, and a delivered entry must really be freed. On master abort, a design that ignored the acknowledge would drive all ones onto the upper half. On a single-phase fetch with a multi-DWORD repeat, a wrong design would report Completion. Requests during data return and with a full queue must not capture a slot or issue a fetch.

// File: rtl/drc_pkg.sv
package drc_pkg;
  typedef enum logic [2:0] {
    CMD_MRD   = 3'd0,
    CMD_MRL   = 3'd1,
    CMD_MRM   = 3'd2,
    CMD_IORD  = 3'd3,
    CMD_CFGRD = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    TT_NORMAL = 2'd0,
    TT_DISC   = 2'd1,
    TT_TABT   = 2'd2,
    TT_MABT   = 2'd3
  } tterm_e;

  typedef enum logic [2:0] {
    RSP_RETRY    = 3'd0,
    RSP_COMPLETE = 3'd1,
    RSP_DISC     = 3'd2,
    RSP_TABT     = 3'd3,
    RSP_MABT     = 3'd4
  } rsp_e;
endpackage

// File: rtl/drc_prefetch.sv
module drc_prefetch #(
  parameter int BYTES_W = 9
) (
  input  logic [2:0]         cmd,
  input  logic               pref,
  input  logic               up,
  input  logic [7:0]         cls,
  input  logic               prom_dn,
  input  logic               prom_up,
  output logic [BYTES_W-1:0] bytes
);
  import drc_pkg::*;

  localparam logic [BYTES_W-1:0] SZ4   = BYTES_W'(4);
  localparam logic [BYTES_W-1:0] SZ32  = BYTES_W'(32);
  localparam logic [BYTES_W-1:0] SZ64  = BYTES_W'(64);
  localparam logic [BYTES_W-1:0] SZ128 = BYTES_W'(128);
  localparam logic [BYTES_W-1:0] SZ256 = BYTES_W'(256);

  logic               line16;
  logic               promo;
  logic [BYTES_W-1:0] base;

  always_comb begin
    line16 = (cls == 8'd16);
    base   = line16 ? SZ64 : SZ32;
    promo  = up ? prom_up : prom_dn;
    if (!pref || cmd == CMD_IORD || cmd == CMD_CFGRD) begin
      bytes = SZ4;
    end else begin
      case (cmd)
        CMD_MRD: bytes = base;
        CMD_MRL: bytes = promo ? ((up && line16) ? SZ128 : SZ64) : base;
        CMD_MRM: bytes = up ? SZ256 : SZ64;
        default: bytes = SZ4;
      endcase
    end
  end
endmodule

// File: rtl/drc_match.sv
module drc_match #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 32,
  parameter int BE_W    = 8,
  localparam int TAG_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]             valid,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] e_addr,
  input  logic [ENTRIES-1:0][2:0]        e_cmd,
  input  logic [ENTRIES-1:0][BE_W-1:0]   e_be,
  input  logic [ENTRIES-1:0]             e_64,
  input  logic [ADDR_W-1:0]              q_addr,
  input  logic [2:0]                     q_cmd,
  input  logic [BE_W-1:0]                q_be,
  input  logic                           q_64,
  output logic [ENTRIES-1:0]             hit_vec,
  output logic                           hit,
  output logic [TAG_W-1:0]               hit_idx,
  output logic                           free_any,
  output logic [TAG_W-1:0]               free_idx
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = valid[i] && (e_addr[i] == q_addr) && (e_cmd[i] == q_cmd)
                        && (e_be[i] == q_be) && (e_64[i] == q_64);
  end

  always_comb begin
    hit      = 1'b0;
    hit_idx  = '0;
    free_any = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit     = 1'b1;
        hit_idx = TAG_W'(i);
      end
      if (!valid[i]) begin
        free_any = 1'b1;
        free_idx = TAG_W'(i);
      end
    end
  end
endmodule

// File: rtl/drc_data_ram.sv
module drc_data_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/drc_tracker.sv
module drc_tracker #(
  parameter int ENTRIES   = 4,
  parameter int ADDR_W    = 32,
  parameter int BE_W      = 8,
  parameter int MAX_WORDS = 64,
  localparam int TAG_W    = $clog2(ENTRIES),
  localparam int IDX_W    = $clog2(MAX_WORDS),
  localparam int CNT_W    = IDX_W + 1,
  localparam int BYTES_W  = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [7:0]         cls,
  input  logic               prom_dn,
  input  logic               prom_up,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [2:0]         req_cmd,
  input  logic [BE_W-1:0]    req_be,
  input  logic               req_64,
  input  logic               req_pref,
  input  logic               req_up,
  input  logic               req_multi,
  output logic               rsp_valid,
  output logic [2:0]         rsp_code,
  output logic               iss_valid,
  output logic [TAG_W-1:0]   iss_tag,
  output logic [ADDR_W-1:0]  iss_addr,
  output logic [2:0]         iss_cmd,
  output logic [BYTES_W-1:0] iss_bytes,
  input  logic               tw_valid,
  input  logic [TAG_W-1:0]   tw_tag,
  input  logic [IDX_W-1:0]   tw_idx,
  input  logic [31:0]        tw_data,
  input  logic               td_valid,
  input  logic [TAG_W-1:0]   td_tag,
  input  logic [1:0]         td_term,
  input  logic [CNT_W-1:0]   td_words,
  input  logic               td_ack64,
  output logic               dat_valid,
  output logic               dat_last,
  output logic [63:0]        dat
);
  import drc_pkg::*;

  localparam int RAM_DEPTH = ENTRIES * MAX_WORDS;

  logic [ENTRIES-1:0]             e_valid, e_done, e_64, e_single, e_ack64;
  logic [ENTRIES-1:0][ADDR_W-1:0] e_addr;
  logic [ENTRIES-1:0][2:0]        e_cmd;
  logic [ENTRIES-1:0][BE_W-1:0]   e_be;
  logic [ENTRIES-1:0][1:0]        e_term;
  logic [ENTRIES-1:0][CNT_W-1:0]  e_words;

  logic [ENTRIES-1:0] hit_vec;
  logic               hit, free_any;
  logic [TAG_W-1:0]   hit_idx, free_idx;
  logic [BYTES_W-1:0] fetch_bytes;

  logic             sending, s_ma, s_wide, s_last;
  logic [TAG_W-1:0] s_tag;
  logic [IDX_W-1:0] s_idx;
  logic [CNT_W-1:0] s_cnt;
  logic             b_ma, b_wide;
  logic [31:0]      rd_word;

  drc_prefetch #(.BYTES_W(BYTES_W)) u_pf (
    .cmd(req_cmd), .pref(req_pref), .up(req_up), .cls(cls),
    .prom_dn(prom_dn), .prom_up(prom_up), .bytes(fetch_bytes)
  );

  drc_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .BE_W(BE_W)) u_match (
    .valid(e_valid), .e_addr(e_addr), .e_cmd(e_cmd), .e_be(e_be), .e_64(e_64),
    .q_addr(req_addr), .q_cmd(req_cmd), .q_be(req_be), .q_64(req_64),
    .hit_vec(hit_vec), .hit(hit), .hit_idx(hit_idx),
    .free_any(free_any), .free_idx(free_idx)
  );

  drc_data_ram #(.DW(32), .DEPTH(RAM_DEPTH)) u_ram (
    .clk(clk), .we(tw_valid), .waddr({tw_tag, tw_idx}), .wdata(tw_data),
    .re(sending && !s_ma), .raddr({s_tag, s_idx}), .rdata(rd_word)
  );

  assign s_last = s_ma || ({1'b0, s_idx} == (s_cnt - 1'b1));

  always_ff @(posedge clk) begin
    if (rst) begin
      e_valid   <= '0;
      e_done    <= '0;
      rsp_valid <= 1'b0;
      rsp_code  <= RSP_RETRY;
      iss_valid <= 1'b0;
      sending   <= 1'b0;
      dat_valid <= 1'b0;
      dat_last  <= 1'b0;
      b_ma      <= 1'b0;
      b_wide    <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      iss_valid <= 1'b0;
      dat_valid <= 1'b0;
      dat_last  <= 1'b0;

      if (td_valid) begin
        e_done[td_tag]  <= 1'b1;
        e_term[td_tag]  <= td_term;
        e_words[td_tag] <= td_words;
        e_ack64[td_tag] <= td_ack64;
      end

      if (sending) begin
        dat_valid <= 1'b1;
        dat_last  <= s_last;
        b_ma      <= s_ma;
        b_wide    <= s_wide;
        s_idx     <= s_idx + 1'b1;
        if (s_last) begin
          sending        <= 1'b0;
          e_valid[s_tag] <= 1'b0;
          e_done[s_tag]  <= 1'b0;
        end
      end

      if (req_valid) begin
        rsp_valid <= 1'b1;
        rsp_code  <= RSP_RETRY;
        if (!sending) begin
          if (hit) begin
            if (e_done[hit_idx]) begin
              case (tterm_e'(e_term[hit_idx]))
                TT_NORMAL: rsp_code <= (e_single[hit_idx] && req_multi) ? RSP_DISC : RSP_COMPLETE;
                TT_DISC:   rsp_code <= RSP_DISC;
                TT_TABT:   rsp_code <= RSP_TABT;
                default:   rsp_code <= RSP_MABT;
              endcase
              s_tag  <= hit_idx;
              s_idx  <= '0;
              s_ma   <= (e_term[hit_idx] == TT_MABT);
              s_wide <= e_64[hit_idx] && e_ack64[hit_idx];
              s_cnt  <= (e_term[hit_idx] == TT_MABT) ? CNT_W'(1) : e_words[hit_idx];
              if (e_term[hit_idx] == TT_MABT ||
                  (e_term[hit_idx] != TT_TABT && e_words[hit_idx] != '0)) begin
                sending <= 1'b1;
              end else begin
                e_valid[hit_idx] <= 1'b0;
                e_done[hit_idx]  <= 1'b0;
              end
            end
          end else if (free_any) begin
            e_valid[free_idx]  <= 1'b1;
            e_done[free_idx]   <= 1'b0;
            e_addr[free_idx]   <= req_addr;
            e_cmd[free_idx]    <= req_cmd;
            e_be[free_idx]     <= req_be;
            e_64[free_idx]     <= req_64;
            e_single[free_idx] <= (fetch_bytes == BYTES_W'(4));
            iss_valid <= 1'b1;
            iss_tag   <= free_idx;
            iss_addr  <= req_addr;
            iss_cmd   <= req_cmd;
            iss_bytes <= fetch_bytes;
          end
        end
      end
    end
  end

  assign dat = b_ma ? {(b_wide ? 32'hFFFF_FFFF : 32'h0), 32'hFFFF_FFFF} : {32'h0, rd_word};

  // R7: a request is captured only when nothing matches, so no two live entries alias
  a_r7_unique_match: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> $onehot0(hit_vec));

  // R1: every issued fetch is paired with a Retry response
  a_r1_issue_retry: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> (rsp_valid && rsp_code == RSP_RETRY));

  // R2..R6: fetch size is always a single power of two
  a_r6_size_pow2: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> ($countones(iss_bytes) == 1));

  // R10: target abort returns no data beat
  a_r10_tabt_nodata: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code == RSP_TABT) |=> !dat_valid);

  // R11: master abort is followed by exactly one final beat
  a_r11_mabt_beat: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code == RSP_MABT) |=> (dat_valid && dat_last));

  // R14: no fetch is issued while data is being returned
  a_r14_no_issue_busy: assert property (@(posedge clk) disable iff (rst)
    (sending && req_valid) |=> !iss_valid);
endmodule

// File: tb/drc_tracker_test.sv
module drc_tracker_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  cls;
  logic        prom_dn, prom_up;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [2:0]  req_cmd;
  logic [7:0]  req_be;
  logic        req_64, req_pref, req_up, req_multi;
  logic        rsp_valid;
  logic [2:0]  rsp_code;
  logic        iss_valid;
  logic [1:0]  iss_tag;
  logic [31:0] iss_addr;
  logic [2:0]  iss_cmd;
  logic [8:0]  iss_bytes;
  logic        tw_valid;
  logic [1:0]  tw_tag;
  logic [5:0]  tw_idx;
  logic [31:0] tw_data;
  logic        td_valid;
  logic [1:0]  td_tag;
  logic [1:0]  td_term;
  logic [6:0]  td_words;
  logic        td_ack64;
  logic        dat_valid, dat_last;
  logic [63:0] dat;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  drc_tracker uut (
    .clk(clk), .rst(rst), .cls(cls), .prom_dn(prom_dn), .prom_up(prom_up),
    .req_valid(req_valid), .req_addr(req_addr), .req_cmd(req_cmd), .req_be(req_be),
    .req_64(req_64), .req_pref(req_pref), .req_up(req_up), .req_multi(req_multi),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_addr(iss_addr), .iss_cmd(iss_cmd),
    .iss_bytes(iss_bytes),
    .tw_valid(tw_valid), .tw_tag(tw_tag), .tw_idx(tw_idx), .tw_data(tw_data),
    .td_valid(td_valid), .td_tag(td_tag), .td_term(td_term), .td_words(td_words),
    .td_ack64(td_ack64),
    .dat_valid(dat_valid), .dat_last(dat_last), .dat(dat)
  );

  // {cmd[3], pref, up, cls[8], prom_dn, prom_up, expected bytes[9]}
  localparam logic [23:0] VEC [NV] = '{
    {3'd0, 1'b1, 1'b0, 8'd8,  1'b0, 1'b0, 9'd32},
    {3'd0, 1'b1, 1'b1, 8'd16, 1'b0, 1'b0, 9'd64},
    {3'd0, 1'b1, 1'b0, 8'd4,  1'b0, 1'b0, 9'd32},
    {3'd0, 1'b1, 1'b1, 8'd0,  1'b0, 1'b0, 9'd32},
    {3'd1, 1'b1, 1'b0, 8'd8,  1'b0, 1'b0, 9'd32},
    {3'd1, 1'b1, 1'b0, 8'd8,  1'b1, 1'b0, 9'd64},
    {3'd1, 1'b1, 1'b0, 8'd16, 1'b1, 1'b0, 9'd64},
    {3'd1, 1'b1, 1'b1, 8'd8,  1'b0, 1'b1, 9'd64},
    {3'd1, 1'b1, 1'b1, 8'd16, 1'b0, 1'b1, 9'd128},
    {3'd1, 1'b1, 1'b1, 8'd16, 1'b1, 1'b0, 9'd64},
    {3'd2, 1'b1, 1'b0, 8'd8,  1'b0, 1'b0, 9'd64},
    {3'd2, 1'b1, 1'b1, 8'd16, 1'b0, 1'b0, 9'd256},
    {3'd2, 1'b1, 1'b1, 8'd32, 1'b0, 1'b0, 9'd256},
    {3'd0, 1'b0, 1'b0, 8'd16, 1'b0, 1'b0, 9'd4},
    {3'd2, 1'b0, 1'b1, 8'd16, 1'b0, 1'b1, 9'd4},
    {3'd3, 1'b1, 1'b0, 8'd16, 1'b1, 1'b1, 9'd4},
    {3'd4, 1'b1, 1'b1, 8'd16, 1'b0, 1'b1, 9'd4}
  };

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // drives one request for a cycle; on return the response is visible
  task automatic do_req(input logic [31:0] a, input logic [2:0] c, input logic [7:0] be,
                        input logic r64, input logic pf, input logic up, input logic mu);
    @(negedge clk);
    req_addr = a; req_cmd = c; req_be = be; req_64 = r64;
    req_pref = pf; req_up = up; req_multi = mu; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic tgt_fill(input logic [1:0] tag, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tw_valid = 1'b1; tw_tag = tag; tw_idx = 6'(i); tw_data = 32'hA000_0000 + 32'(tag) * 256 + 32'(i);
    end
    @(negedge clk);
    tw_valid = 1'b0;
  endtask

  task automatic tgt_done(input logic [1:0] tag, input logic [1:0] term, input logic [6:0] n,
                          input logic a64);
    @(negedge clk);
    td_valid = 1'b1; td_tag = tag; td_term = term; td_words = n; td_ack64 = a64;
    @(negedge clk);
    td_valid = 1'b0;
  endtask

  task automatic expect_beats(input logic [1:0] tag, input int n, input string rq);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(dat_valid && dat == {32'h0, 32'hA000_0000 + 32'(tag) * 256 + 32'(i)}, rq, dat,
          {32'h0, 32'hA000_0000 + 32'(tag) * 256 + 32'(i)});
      chk(dat_last == (i == n - 1), rq, 64'(dat_last), 64'(i == n - 1));
    end
    @(negedge clk);
    chk(!dat_valid, rq, 64'(dat_valid), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; cls = 8'd8; prom_dn = 1'b0; prom_up = 1'b0;
    req_valid = 1'b0; req_addr = '0; req_cmd = '0; req_be = '0;
    req_64 = 1'b0; req_pref = 1'b0; req_up = 1'b0; req_multi = 1'b0;
    tw_valid = 1'b0; tw_tag = '0; tw_idx = '0; tw_data = '0;
    td_valid = 1'b0; td_tag = '0; td_term = '0; td_words = '0; td_ack64 = 1'b0;

    // table walk over fetch-size selection
    for (int v = 0; v < NV; v++) begin
      string rq;
      logic [2:0] c;
      c = VEC[v][23:21];
      if (!VEC[v][20] || c >= 3'd3) rq = "R2";
      else if (c == 3'd1) rq = "R5";
      else if (c == 3'd2) rq = "R6";
      else if (VEC[v][18:11] != 8'd8 && VEC[v][18:11] != 8'd16) rq = "R4";
      else rq = "R3";
      do_reset();
      cls = VEC[v][18:11]; prom_dn = VEC[v][10]; prom_up = VEC[v][9];
      do_req(32'h100 + 32'(v), c, 8'h0F, 1'b0, VEC[v][20], VEC[v][19], 1'b0);
      chk(iss_valid && iss_bytes == VEC[v][8:0], rq, 64'(iss_bytes), 64'(VEC[v][8:0]));
    end

    // reset state
    do_reset();
    cls = 8'd16; prom_dn = 1'b0; prom_up = 1'b1;
    chk(!rsp_valid && !iss_valid && !dat_valid, "reset", {rsp_valid, iss_valid, dat_valid}, 0);

    // R1: capture in slot 0
    do_req(32'h4000, 3'd1, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0);
    chk(rsp_valid && rsp_code == 3'd0, "R1", rsp_code, 0);
    chk(iss_valid && iss_tag == 2'd0 && iss_addr == 32'h4000 && iss_cmd == 3'd1 && iss_bytes == 9'd128,
        "R1", {iss_tag, iss_addr, iss_bytes}, {2'd0, 32'h4000, 9'd128});

    // R8: pending repeat
    do_req(32'h4000, 3'd1, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0);
    chk(rsp_valid && rsp_code == 3'd0 && !iss_valid, "R8", {rsp_code, iss_valid}, 0);

    tgt_fill(2'd0, 4);
    tgt_done(2'd0, 2'd0, 7'd4, 1'b1);

    // R7: differs only in byte enables -> new capture in slot 1
    do_req(32'h4000, 3'd1, 8'h0F, 1'b1, 1'b1, 1'b1, 1'b0);
    chk(rsp_code == 3'd0 && iss_valid && iss_tag == 2'd1, "R7", {rsp_code, iss_valid, iss_tag}, {3'd0, 1'b1, 2'd1});
    chk(!dat_valid, "R7", 64'(dat_valid), 0);

    // R9 with R14 overlap: completion streams 4 words
    do_req(32'h4000, 3'd1, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0);
    chk(rsp_valid && rsp_code == 3'd1, "R9", rsp_code, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (i == 2) begin
        req_valid = 1'b0;
        chk(rsp_valid && rsp_code == 3'd0 && !iss_valid, "R14", {rsp_code, iss_valid}, 0);
      end
      chk(dat_valid && dat == {32'h0, 32'hA000_0000 + 32'(i)}, "R9", dat, {32'h0, 32'hA000_0000 + 32'(i)});
      chk(dat_last == (i == 3), "R9", 64'(dat_last), 64'(i == 3));
      if (i == 1) begin
        req_addr = 32'h9999; req_cmd = 3'd0; req_be = 8'h01; req_64 = 1'b0;
        req_pref = 1'b1; req_up = 1'b0; req_multi = 1'b0; req_valid = 1'b1;
      end
    end
    @(negedge clk);
    chk(!dat_valid, "R9", 64'(dat_valid), 0);

    // R9: entry freed -> same request captured again in slot 0
    do_req(32'h4000, 3'd1, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0);
    chk(iss_valid && iss_tag == 2'd0, "R9", {iss_valid, iss_tag}, {1'b1, 2'd0});

    // R10: target abort on slot 1
    tgt_done(2'd1, 2'd2, 7'd0, 1'b0);
    do_req(32'h4000, 3'd1, 8'h0F, 1'b1, 1'b1, 1'b1, 1'b0);
    chk(rsp_valid && rsp_code == 3'd3, "R10", rsp_code, 3);
    @(negedge clk);
    chk(!dat_valid, "R10", 64'(dat_valid), 0);

    // R11: master abort, 64-bit acknowledged
    do_req(32'h0500, 3'd3, 8'h0F, 1'b1, 1'b0, 1'b0, 1'b0);
    chk(iss_valid && iss_tag == 2'd1 && iss_bytes == 9'd4, "R11", {iss_tag, iss_bytes}, {2'd1, 9'd4});
    tgt_done(2'd1, 2'd3, 7'd0, 1'b1);
    do_req(32'h0500, 3'd3, 8'h0F, 1'b1, 1'b0, 1'b0, 1'b0);
    chk(rsp_code == 3'd4, "R11", rsp_code, 4);
    @(negedge clk);
    chk(dat_valid && dat_last && dat == 64'hFFFF_FFFF_FFFF_FFFF, "R11", dat, 64'hFFFF_FFFF_FFFF_FFFF);
    @(negedge clk);
    chk(!dat_valid, "R11", 64'(dat_valid), 0);

    // R11: master abort, 64-bit requested but not acknowledged
    do_req(32'h0600, 3'd4, 8'h0F, 1'b1, 1'b1, 1'b0, 1'b0);
    tgt_done(2'd1, 2'd3, 7'd0, 1'b0);
    do_req(32'h0600, 3'd4, 8'h0F, 1'b1, 1'b1, 1'b0, 1'b0);
    chk(rsp_code == 3'd4, "R11", rsp_code, 4);
    @(negedge clk);
    chk(dat_valid && dat_last && dat == 64'h0000_0000_FFFF_FFFF, "R11", dat, 64'h0000_0000_FFFF_FFFF);

    // R10: target disconnect with 2 words
    do_req(32'h0700, 3'd0, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0);
    chk(iss_valid && iss_tag == 2'd1, "R10", iss_tag, 1);
    tgt_fill(2'd1, 2);
    tgt_done(2'd1, 2'd1, 7'd2, 1'b0);
    do_req(32'h0700, 3'd0, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0);
    chk(rsp_code == 3'd2, "R10", rsp_code, 2);
    expect_beats(2'd1, 2, "R10");

    // R12: single-phase fetch, multi-DWORD repeat
    do_req(32'h0800, 3'd0, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(iss_valid && iss_tag == 2'd1 && iss_bytes == 9'd4, "R12", iss_bytes, 4);
    tgt_fill(2'd1, 1);
    tgt_done(2'd1, 2'd0, 7'd1, 1'b0);
    do_req(32'h0800, 3'd0, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b1);
    chk(rsp_code == 3'd2, "R12", rsp_code, 2);
    expect_beats(2'd1, 1, "R12");

    // R13: fill slots 1..3, then one more
    for (int k = 1; k < 4; k++) begin
      do_req(32'h1000 + 32'(k), 3'd2, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0);
      chk(iss_valid && iss_tag == 2'(k), "R13", iss_tag, k);
    end
    do_req(32'h2000, 3'd2, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0);
    chk(rsp_valid && rsp_code == 3'd0 && !iss_valid, "R13", {rsp_code, iss_valid}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule